// File: doc/BRIEF.md
# Power-On Mode Strap Sequencer

This block settles the operating configuration of a PC Card style interface controller after power-on. The power-on reset is released. The block then evaluates two board-level straps, one after the other, and reports busy for the whole time it is doing so. It latches the resulting mode flags for the rest of the chip. The interface comes up in memory-only mode by default.

The serial-role strap is evaluated first. A high or floating level gives serial master mode, in which an external EEPROM supplies the configuration. A low level gives serial slave mode, in which an external microprocessor configures the device over the serial pins. The ATA-select strap is evaluated second. It must read low on every sample of a qualification window that is `WIN_LEN` clock cycles long (default 40) before ATA passthrough is chosen. A single high sample inside the window cancels the choice, and the mode stays memory-only.

Once both decisions are held, the block emits a one-cycle done pulse that starts the downstream configuration loader. Busy stays asserted until that loader reports ready. Both straps pass through two-flop synchronizers. The internal reset is asserted asynchronously and released synchronously.

Top module: `strap_seq`

## Requirements
- R1: While `por_n` is low, `busy_o`=1, `done_o`=0, `ata_pass_o`=0, `mem_only_o`=1 and `ser_master_o`=1.
- R2: If the serial-role strap was high on the first clock edge after `por_n` rose, `ser_master_o` latches 1 (master mode).
- R3: If the serial-role strap was low on the first clock edge after `por_n` rose, `ser_master_o` latches 0 (slave mode).
- R4: Changes of the serial-role strap after that first edge have no effect on `ser_master_o`.
- R5: If the ATA-select strap is low on all `WIN_LEN` window samples, `ata_pass_o` becomes 1 and `mem_only_o` becomes 0. `done_o` is then high in the cycle after edge 43 counted from `por_n` release (default parameters).
- R6: A high ATA-select sample anywhere in the window aborts qualification at once. `ata_pass_o` stays 0, `mem_only_o` stays 1, and `done_o` follows in the next cycle. A strap held high gives done after edge 4.
- R7: The window samples the strap levels present at edges 2 through 41 after release. A high level at edge 1 or edge 42 is ignored, while a high level at edge 2 or edge 41 aborts.
- R8: `done_o` is high for exactly one cycle, once per reset.
- R9: `busy_o` stays 1 through the done pulse. It falls only after `ldr_ready_i` is sampled high in a cycle after the pulse. `ldr_ready_i` before or during the pulse is ignored. Once low, `busy_o` stays low.
- R10: Once `busy_o` is low, the mode flags hold their values until the next reset, whatever the straps do.
- R11: Pulling `por_n` low forces the R1 values immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous assert |
| strap_master_i | input | 1 | Serial-role strap, high or floating = master |
| strap_ata_i | input | 1 | ATA-select strap, low qualifies passthrough |
| ldr_ready_i | input | 1 | Ready indication from the configuration loader |
| busy_o | output | 1 | 1 = busy, 0 = ready |
| ser_master_o | output | 1 | 1 = serial master, 0 = serial slave |
| ata_pass_o | output | 1 | ATA passthrough selected |
| mem_only_o | output | 1 | Memory-only interface mode |
| done_o | output | 1 | One-cycle pulse when all decisions are latched |

## Verification
The hardest situation to reach is a strap level that changes on exactly the first or the last sample of the qualification window. These samples are hidden behind the synchronizer delay and the serial decision cycle. The bench counts clock edges from reset release and places single-cycle high pulses on the ATA strap at edges 1, 2, 41 and 42. It then checks both the chosen mode and the exact cycle of the done pulse, so an off-by-one at either end of the window shows up. It also raises the loader ready input during the done pulse itself, to show that busy is not released early.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

    typedef enum logic [2:0] {
        ST_SER   = 3'd0,
        ST_WIN   = 3'd1,
        ST_DONE  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_READY = 3'd4
    } seq_state_e;

    localparam int unsigned DEF_WIN_LEN     = 40;
    localparam int unsigned DEF_SYNC_STAGES = 2;
    localparam int unsigned DEF_RST_STAGES  = 2;

endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        stage_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/strap_win_ctr.sv
module strap_win_ctr #(
    parameter int unsigned WIN_LEN = 40,
    localparam int unsigned CW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CW'(WIN_LEN - 1));
endmodule

// File: rtl/strap_seq.sv
module strap_seq
    import strap_seq_pkg::*;
#(
    parameter int unsigned WIN_LEN     = DEF_WIN_LEN,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int unsigned RST_STAGES  = DEF_RST_STAGES
) (
    input  logic clk,
    input  logic por_n,
    input  logic strap_master_i,
    input  logic strap_ata_i,
    input  logic ldr_ready_i,
    output logic busy_o,
    output logic ser_master_o,
    output logic ata_pass_o,
    output logic mem_only_o,
    output logic done_o
);
    localparam int unsigned N_STRAPS = 2;
    localparam int unsigned IDX_MST  = 0;
    localparam int unsigned IDX_ATA  = 1;

    typedef struct packed {
        seq_state_e state;
        logic       ser_master;
        logic       ata_pass;
    } seq_regs_t;

    localparam seq_regs_t REGS_RST = '{state: ST_SER, ser_master: 1'b1, ata_pass: 1'b0};

    logic                rst_n;
    logic [N_STRAPS-1:0] strap_raw, strap_s;
    logic                ctr_clr, ctr_inc, ctr_last;
    seq_regs_t           regs_d, regs_q;

    strap_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
        .clk     (clk),
        .arst_n  (por_n),
        .rst_n_o (rst_n)
    );

    assign strap_raw[IDX_MST] = strap_master_i;
    assign strap_raw[IDX_ATA] = strap_ata_i;

    strap_sync #(.WIDTH(N_STRAPS), .STAGES(SYNC_STAGES)) strap_sync_i (
        .clk  (clk),
        .din  (strap_raw),
        .dout (strap_s)
    );

    strap_win_ctr #(.WIN_LEN(WIN_LEN)) win_ctr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ctr_clr),
        .inc_i  (ctr_inc),
        .last_o (ctr_last)
    );

    always_comb begin
        regs_d  = regs_q;
        ctr_clr = 1'b0;
        ctr_inc = 1'b0;
        case (regs_q.state)
            ST_SER: begin
                regs_d.ser_master = strap_s[IDX_MST];
                ctr_clr           = 1'b1;
                regs_d.state      = ST_WIN;
            end
            ST_WIN: begin
                if (strap_s[IDX_ATA]) begin
                    regs_d.ata_pass = 1'b0;
                    regs_d.state    = ST_DONE;
                end else if (ctr_last) begin
                    regs_d.ata_pass = 1'b1;
                    regs_d.state    = ST_DONE;
                end else begin
                    ctr_inc = 1'b1;
                end
            end
            ST_DONE:  regs_d.state = ST_WAIT;
            ST_WAIT:  if (ldr_ready_i) regs_d.state = ST_READY;
            ST_READY: regs_d.state = ST_READY;
            default:  regs_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    assign busy_o       = (regs_q.state != ST_READY);
    assign done_o       = (regs_q.state == ST_DONE);
    assign ser_master_o = regs_q.ser_master;
    assign ata_pass_o   = regs_q.ata_pass;
    assign mem_only_o   = ~regs_q.ata_pass;
endmodule

// File: rtl/strap_seq_chk.sv
module strap_seq_chk (
    input logic clk,
    input logic por_n,
    input logic ldr_ready_i,
    input logic busy_o,
    input logic ser_master_o,
    input logic ata_pass_o,
    input logic done_o
);
    // R1
    reset_values_chk: assert property (@(posedge clk)
        !por_n |-> (busy_o && !done_o && !ata_pass_o && ser_master_o));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        done_o |=> !done_o);

    // R9
    done_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
        done_o |-> busy_o);

    // R9
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        !busy_o |=> !busy_o);

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !busy_o |=> $stable({ser_master_o, ata_pass_o}));

    // R5
    pass_with_done_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(ata_pass_o) |-> done_o);

    // R9
    busy_needs_ready_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(busy_o) |-> $past(ldr_ready_i));
endmodule

bind strap_seq strap_seq_chk chk_i (
    .clk          (clk),
    .por_n        (por_n),
    .ldr_ready_i  (ldr_ready_i),
    .busy_o       (busy_o),
    .ser_master_o (ser_master_o),
    .ata_pass_o   (ata_pass_o),
    .done_o       (done_o)
);

// File: tb/strap_seq_tb_top.sv
module strap_seq_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic por_n = 1'b1, strap_master = 1'b1, strap_ata = 1'b0, ldr_ready = 1'b0;
    logic busy, ser_master, ata_pass, mem_only, done;

    int n_tests = 0, n_fail = 0, rel_cyc = 0, done_seen = 0;

    typedef struct {
        string tag;
        bit    ser;
        bit    ata;
        int    lat;
    } exp_t;
    exp_t exp_q[$];

    strap_seq dut_i (
        .clk            (clk),
        .por_n          (por_n),
        .strap_master_i (strap_master),
        .strap_ata_i    (strap_ata),
        .ldr_ready_i    (ldr_ready),
        .busy_o         (busy),
        .ser_master_o   (ser_master),
        .ata_pass_o     (ata_pass),
        .mem_only_o     (mem_only),
        .done_o         (done)
    );

    always @(posedge clk) begin
        if (!por_n) rel_cyc <= 0;
        else        rel_cyc <= rel_cyc + 1;
    end

    task automatic check(input string req, input string what, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // scoreboard monitor: pops one expected item per done pulse
    always @(negedge clk) begin
        exp_t e;
        if (por_n && done) begin
            done_seen++;
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R8 unexpected done: actual 1 expected 0");
            end else begin
                e = exp_q.pop_front();
                check("R2/R3", {e.tag, " ser_master"}, int'(ser_master), int'(e.ser));
                check("R5/R6", {e.tag, " ata_pass"}, int'(ata_pass), int'(e.ata));
                check("R5/R6", {e.tag, " mem_only"}, int'(mem_only), int'(!e.ata));
                check("R5/R6/R7", {e.tag, " done latency"}, rel_cyc, e.lat);
            end
        end
    end

    // amode: 0 = ATA strap low, 1 = held high, 2 = one-cycle high pulse at edge j
    task automatic run_case(input string tag, input bit m, input int amode, input int j,
                            input int mflip, input bit exp_ata, input int exp_lat);
        exp_t e;
        @(posedge clk);
        #2 por_n = 1'b0;
        #1;
        check("R11", {tag, " async busy"}, int'(busy), 1);
        check("R11", {tag, " async mem_only"}, int'(mem_only), 1);
        strap_master = m;
        strap_ata    = (amode == 1);
        ldr_ready    = 1'b0;
        repeat (4) @(negedge clk);
        check("R1", {tag, " reset busy"}, int'(busy), 1);
        check("R1", {tag, " reset done"}, int'(done), 0);
        check("R1", {tag, " reset ata_pass"}, int'(ata_pass), 0);
        check("R1", {tag, " reset ser_master"}, int'(ser_master), 1);
        e.tag = tag; e.ser = m; e.ata = exp_ata; e.lat = exp_lat;
        exp_q.push_back(e);
        done_seen = 0;
        strap_ata = (amode == 1) || (amode == 2 && j == 1);
        por_n     = 1'b1;
        for (int c = 1; c <= 60; c++) begin
            @(negedge clk);
            strap_ata    = (amode == 1) || (amode == 2 && rel_cyc == j - 1);
            strap_master = (mflip != 0 && c >= mflip) ? !m : m;
            ldr_ready    = (c == 2) || (c == exp_lat);
        end
        @(negedge clk);
        ldr_ready = 1'b0;
        check("R9", {tag, " busy before loader ready"}, int'(busy), 1);
        check("R8", {tag, " done pulse count"}, done_seen, 1);
        check("R4", {tag, " ser_master held"}, int'(ser_master), int'(m));
        ldr_ready = 1'b1;
        @(negedge clk);
        ldr_ready = 1'b0;
        check("R9", {tag, " busy after loader ready"}, int'(busy), 0);
        for (int c = 0; c < 5; c++) begin
            strap_master = c[0];
            strap_ata    = ~c[0];
            @(negedge clk);
        end
        check("R10", {tag, " ser_master stable"}, int'(ser_master), int'(m));
        check("R10", {tag, " ata_pass stable"}, int'(ata_pass), int'(exp_ata));
        check("R9", {tag, " busy stays low"}, int'(busy), 0);
    endtask

    initial begin
        #(2_000_000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        run_case("R2 R5 master+pass",     1'b1, 0, 0,  0,  1'b1, 43);
        run_case("R3 R6 slave+held_high", 1'b0, 1, 0,  0,  1'b0, 4);
        run_case("R4 R6 mid_pulse",       1'b0, 2, 20, 10, 1'b0, 22);
        run_case("R7 last_sample",        1'b1, 2, 41, 0,  1'b0, 43);
        run_case("R7 after_window",       1'b1, 2, 42, 0,  1'b1, 43);
        run_case("R7 first_sample",       1'b0, 2, 2,  0,  1'b0, 4);
        run_case("R7 before_window",      1'b1, 2, 1,  0,  1'b1, 43);
        check("R8", "leftover expected items", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule